// File: doc/BRIEF.md
# Synchronous Clock Stop Gating

This block gates a set of clock outputs so that they can be stopped and restarted without runt pulses. Two source clocks are presented to it as digital waveforms: a bus clock feeding a group of stoppable outputs and a group of free-running outputs, and a processor clock feeding a set of differential output pairs. A fast internal sampling clock observes both sources, detects their edges, and recomputes every gate only while the corresponding output is low.

Two active-low stop requests act on the design. Each is captured on two consecutive rising edges of its own source clock before it takes effect. A bus-clock stop holds the stoppable outputs low from a falling edge onward and leaves the free-running ones untouched. A processor-clock stop parks each differential pair with the true side low and the complement side high. The stop requests are honoured only when a mode input, captured while reset is held, is 1. Per-output enable bits can switch off any output independently of the stop requests.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is held, every bus output and every true processor output is 0 and every complement output is 1; after reset they stay so until the first source falling edge, then follow their source.
- R2: With the latched mode at 1, driving `pci_stop_n` low lets each stoppable bus output give at most two more rising edges, after which it stays low.
- R3: The free-running bus outputs keep toggling with the bus source while `pci_stop_n` is low.
- R4: Raising `pci_stop_n` again makes the stopped bus outputs resume toggling within a few source periods.
- R5: Every high phase of a bus output lasts exactly one high phase of the bus source, and a bus output only falls while the source is low.
- R6: With the latched mode at 1, driving `cpu_stop_n` low lets each true processor output give at most two more rising edges, after which it holds 0 and its complement holds 1; bus outputs are unaffected.
- R7: While running, each complement output is the inverse of its true output, each true high phase lasts one processor source high phase, and the pairs resume after `cpu_stop_n` rises.
- R8: `mode_pin` is captured only while `rst_n` is low; with the captured value 0 both stop inputs have no effect, and changing `mode_pin` after reset changes nothing.
- R9: Bit i of `pci_en`, `free_en` or `cpu_en` at 0 disables output i of that group from its next source falling edge: a bus output is held low, a processor pair parks at true 0 and complement 1; the other outputs keep toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than both sources |
| rst_n | input | 1 | Active-low reset |
| mode_pin | input | 1 | Stop-enable mode, captured during reset |
| pci_clk_in | input | 1 | Bus source clock waveform |
| cpu_clk_in | input | 1 | Processor source clock waveform |
| pci_stop_n | input | 1 | Active-low stop request for stoppable bus outputs |
| cpu_stop_n | input | 1 | Active-low stop request for processor pairs |
| pci_en | input | N_PCI | Enable per stoppable bus output |
| free_en | input | N_FREE | Enable per free-running bus output |
| cpu_en | input | N_CPU | Enable per processor pair |
| pci_out | output | N_PCI | Stoppable bus clock outputs |
| free_out | output | N_FREE | Free-running bus clock outputs |
| cpu_t | output | N_CPU | True side of processor pairs |
| cpu_c | output | N_CPU | Complement side of processor pairs |

## Verification
The bench builds the block with three stoppable outputs, two free-running outputs and two processor pairs, so every enable bit position and both output groups are reached with small vectors. The bus source runs at one eighth and the processor source at one quarter of the sampling clock, which puts the two-edge stop capture, the parking edge and the resume edge inside short windows where pulse counts and every high-phase width can be measured exactly.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_PCI  = 6,
  parameter int N_FREE = 2,
  parameter int N_CPU  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic              pci_clk_in,
  input  logic              cpu_clk_in,
  input  logic              pci_stop_n,
  input  logic              cpu_stop_n,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_FREE-1:0] free_en,
  input  logic [N_CPU-1:0]  cpu_en,
  output logic [N_PCI-1:0]  pci_out,
  output logic [N_FREE-1:0] free_out,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c
);

  logic       mode_q;
  logic       p_q, p_prev, c_q, c_prev;
  logic [1:0] p_sync, c_sync;
  logic       p_rise, p_fall, c_rise, c_fall;
  logic       pci_halt, cpu_halt;

  logic [N_PCI-1:0]  pci_run;
  logic [N_FREE-1:0] free_run;
  logic [N_CPU-1:0]  cpu_park;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= mode_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q    <= 1'b0;
      p_prev <= 1'b0;
      c_q    <= 1'b0;
      c_prev <= 1'b0;
      p_sync <= 2'b11;
      c_sync <= 2'b11;
    end else begin
      p_q    <= pci_clk_in;
      p_prev <= p_q;
      c_q    <= cpu_clk_in;
      c_prev <= c_q;
      if (p_rise) p_sync <= {p_sync[0], pci_stop_n};
      if (c_rise) c_sync <= {c_sync[0], cpu_stop_n};
    end
  end

  assign p_rise   = p_q & ~p_prev;
  assign p_fall   = ~p_q & p_prev;
  assign c_rise   = c_q & ~c_prev;
  assign c_fall   = ~c_q & c_prev;
  assign pci_halt = mode_q & ~p_sync[1];
  assign cpu_halt = mode_q & ~c_sync[1];

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      pci_run[i] <= 1'b0;
      else if (p_fall) pci_run[i] <= pci_en[i] & ~pci_halt;
    assign pci_out[i] = p_q & pci_run[i];
  end

  for (genvar i = 0; i < N_FREE; i++) begin : g_free
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      free_run[i] <= 1'b0;
      else if (p_fall) free_run[i] <= free_en[i];
    assign free_out[i] = p_q & free_run[i];
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cpu_park[i] <= 1'b1;
      else if (c_fall) cpu_park[i] <= ~cpu_en[i] | cpu_halt;
    assign cpu_t[i] = c_q & ~cpu_park[i];
    assign cpu_c[i] = ~cpu_t[i];
  end

endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int N_PCI  = 6,
  parameter int N_FREE = 2,
  parameter int N_CPU  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pci_clk_in,
  input logic              cpu_clk_in,
  input logic              mode_q,
  input logic [N_PCI-1:0]  pci_out,
  input logic [N_FREE-1:0] free_out,
  input logic [N_CPU-1:0]  cpu_t
);

  for (genvar i = 0; i < N_PCI; i++) begin : g_pa
    assert_pci_fall_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pci_out[i]) |-> !$past(pci_clk_in));
  end

  for (genvar i = 0; i < N_FREE; i++) begin : g_fa
    assert_free_fall_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(free_out[i]) |-> !$past(pci_clk_in));
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_ca
    assert_cpu_fall_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_t[i]) |-> !$past(cpu_clk_in));
    assert_cpu_rise_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_t[i]) |-> $past(cpu_clk_in));
  end

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .N_PCI(N_PCI), .N_FREE(N_FREE), .N_CPU(N_CPU)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pci_clk_in(pci_clk_in), .cpu_clk_in(cpu_clk_in),
  .mode_q(mode_q), .pci_out(pci_out), .free_out(free_out), .cpu_t(cpu_t)
);

// File: tb/test_clk_stop_gate.sv
module test_clk_stop_gate;
  localparam int N_PCI  = 3;
  localparam int N_FREE = 2;
  localparam int N_CPU  = 2;
  localparam int PH     = 4;
  localparam int CH     = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pin = 1'b1;
  logic pci_src = 1'b0;
  logic cpu_src = 1'b0;
  logic pci_stop_n = 1'b1;
  logic cpu_stop_n = 1'b1;
  logic [N_PCI-1:0]  pci_en  = '1;
  logic [N_FREE-1:0] free_en = '1;
  logic [N_CPU-1:0]  cpu_en  = '1;
  logic [N_PCI-1:0]  pci_out;
  logic [N_FREE-1:0] free_out;
  logic [N_CPU-1:0]  cpu_t, cpu_c;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  clk_stop_gate #(.N_PCI(N_PCI), .N_FREE(N_FREE), .N_CPU(N_CPU)) i_clk_stop_gate (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin),
    .pci_clk_in(pci_src), .cpu_clk_in(cpu_src),
    .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
    .pci_en(pci_en), .free_en(free_en), .cpu_en(cpu_en),
    .pci_out(pci_out), .free_out(free_out), .cpu_t(cpu_t), .cpu_c(cpu_c)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int pcnt = 0, ccnt = 0;
  always @(negedge clk) begin
    if (pcnt == PH - 1) begin pcnt = 0; pci_src = ~pci_src; end else pcnt++;
    if (ccnt == CH - 1) begin ccnt = 0; cpu_src = ~cpu_src; end else ccnt++;
  end

  int p_rises [N_PCI];
  int f_rises [N_FREE];
  int c_rises [N_CPU];
  int p_w [N_PCI];
  int f_w [N_FREE];
  int c_w [N_CPU];
  logic [N_PCI-1:0]  p_prev = '0;
  logic [N_FREE-1:0] f_prev = '0;
  logic [N_CPU-1:0]  c_prev = '0;

  initial begin
    for (int i = 0; i < N_PCI; i++) begin p_rises[i] = 0; p_w[i] = 0; end
    for (int i = 0; i < N_FREE; i++) begin f_rises[i] = 0; f_w[i] = 0; end
    for (int i = 0; i < N_CPU; i++) begin c_rises[i] = 0; c_w[i] = 0; end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      p_prev = '0; f_prev = '0; c_prev = '0;
      for (int i = 0; i < N_PCI; i++) p_w[i] = 0;
      for (int i = 0; i < N_FREE; i++) f_w[i] = 0;
      for (int i = 0; i < N_CPU; i++) c_w[i] = 0;
    end else begin
      for (int i = 0; i < N_PCI; i++) begin
        if (pci_out[i]) p_w[i]++;
        if (pci_out[i] && !p_prev[i]) p_rises[i]++;
        if (!pci_out[i] && p_prev[i]) begin
          check(p_w[i] == PH, "R5 stoppable high width", p_w[i], PH);
          p_w[i] = 0;
        end
        p_prev[i] = pci_out[i];
      end
      for (int i = 0; i < N_FREE; i++) begin
        if (free_out[i]) f_w[i]++;
        if (free_out[i] && !f_prev[i]) f_rises[i]++;
        if (!free_out[i] && f_prev[i]) begin
          check(f_w[i] == PH, "R5 free high width", f_w[i], PH);
          f_w[i] = 0;
        end
        f_prev[i] = free_out[i];
      end
      for (int i = 0; i < N_CPU; i++) begin
        if (cpu_t[i]) c_w[i]++;
        if (cpu_t[i] && !c_prev[i]) c_rises[i]++;
        if (!cpu_t[i] && c_prev[i]) begin
          check(c_w[i] == CH, "R7 true high width", c_w[i], CH);
          c_w[i] = 0;
        end
        c_prev[i] = cpu_t[i];
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input logic m);
    mode_pin = m;
    rst_n = 1'b0;
    tick(6);
    rst_n = 1'b1;
    mode_pin = ~m;
    tick(1);
  endtask

  task automatic t_reset_state();
    mode_pin = 1'b1;
    rst_n = 1'b0;
    tick(6);
    check(pci_out == '0, "R1 reset stoppable", int'(pci_out), 0);
    check(free_out == '0, "R1 reset free", int'(free_out), 0);
    check(cpu_t == '0, "R1 reset true", int'(cpu_t), 0);
    check(cpu_c == '1, "R1 reset complement", int'(cpu_c), (1 << N_CPU) - 1);
    rst_n = 1'b1;
    mode_pin = 1'b0;
    tick(1);
    check(pci_out == '0 && cpu_t == '0, "R1 low right after reset", int'(pci_out), 0);
    begin
      int sp [N_PCI]; int sf [N_FREE]; int sc [N_CPU];
      sp = p_rises; sf = f_rises; sc = c_rises;
      tick(40);
      for (int i = 0; i < N_PCI; i++) check(p_rises[i] - sp[i] >= 3, "R1 stoppable starts", p_rises[i] - sp[i], 3);
      for (int i = 0; i < N_FREE; i++) check(f_rises[i] - sf[i] >= 3, "R1 free starts", f_rises[i] - sf[i], 3);
      for (int i = 0; i < N_CPU; i++) check(c_rises[i] - sc[i] >= 7, "R1 pair starts", c_rises[i] - sc[i], 7);
    end
  endtask

  task automatic t_pci_stop();
    int sp [N_PCI]; int sf [N_FREE]; int sc [N_CPU];
    sp = p_rises; sf = f_rises; sc = c_rises;
    pci_stop_n = 1'b0;
    tick(32);
    for (int i = 0; i < N_PCI; i++) begin
      int d = p_rises[i] - sp[i];
      check(d >= 1 && d <= 2, "R2 pulses after stop", d, 2);
    end
    sp = p_rises;
    tick(48);
    for (int i = 0; i < N_PCI; i++) check(p_rises[i] == sp[i], "R2 held stopped", p_rises[i] - sp[i], 0);
    check(pci_out == '0, "R2 stopped level", int'(pci_out), 0);
    for (int i = 0; i < N_FREE; i++) check(f_rises[i] - sf[i] >= 9, "R3 free runs during stop", f_rises[i] - sf[i], 9);
    for (int i = 0; i < N_CPU; i++) check(c_rises[i] - sc[i] >= 18, "R2 pairs unaffected", c_rises[i] - sc[i], 18);
    pci_stop_n = 1'b1;
    sp = p_rises;
    tick(48);
    for (int i = 0; i < N_PCI; i++) check(p_rises[i] - sp[i] >= 2, "R4 resume", p_rises[i] - sp[i], 2);
  endtask

  task automatic t_cpu_stop();
    int sp [N_PCI]; int sc [N_CPU];
    sp = p_rises; sc = c_rises;
    cpu_stop_n = 1'b0;
    tick(16);
    for (int i = 0; i < N_CPU; i++) begin
      int d = c_rises[i] - sc[i];
      check(d >= 1 && d <= 2, "R6 pulses after stop", d, 2);
    end
    sc = c_rises;
    tick(24);
    for (int i = 0; i < N_CPU; i++) check(c_rises[i] == sc[i], "R6 held parked", c_rises[i] - sc[i], 0);
    check(cpu_t == '0, "R6 parked true", int'(cpu_t), 0);
    check(cpu_c == '1, "R6 parked complement", int'(cpu_c), (1 << N_CPU) - 1);
    for (int i = 0; i < N_PCI; i++) check(p_rises[i] - sp[i] >= 4, "R6 bus unaffected", p_rises[i] - sp[i], 4);
    cpu_stop_n = 1'b1;
    sc = c_rises;
    tick(24);
    for (int i = 0; i < N_CPU; i++) check(c_rises[i] - sc[i] >= 2, "R7 pair resumes", c_rises[i] - sc[i], 2);
  endtask

  task automatic t_complement();
    int bad = 0;
    for (int k = 0; k < 16; k++) begin
      if (cpu_c !== ~cpu_t) bad++;
      tick(1);
    end
    check(bad == 0, "R7 complement inverse", bad, 0);
  endtask

  task automatic t_enables();
    int sp [N_PCI]; int sf [N_FREE]; int sc [N_CPU];
    pci_en[1] = 1'b0; free_en[0] = 1'b0; cpu_en[1] = 1'b0;
    tick(16);
    sp = p_rises; sf = f_rises; sc = c_rises;
    tick(48);
    check(p_rises[1] == sp[1] && !pci_out[1], "R9 disabled stoppable", p_rises[1] - sp[1], 0);
    check(p_rises[0] - sp[0] >= 5 && p_rises[2] - sp[2] >= 5, "R9 other stoppable run", p_rises[0] - sp[0], 5);
    check(f_rises[0] == sf[0] && !free_out[0], "R9 disabled free", f_rises[0] - sf[0], 0);
    check(f_rises[1] - sf[1] >= 5, "R9 other free runs", f_rises[1] - sf[1], 5);
    check(c_rises[1] == sc[1] && !cpu_t[1] && cpu_c[1], "R9 disabled pair parks", c_rises[1] - sc[1], 0);
    check(c_rises[0] - sc[0] >= 11, "R9 other pair runs", c_rises[0] - sc[0], 11);
    pci_en = '1; free_en = '1; cpu_en = '1;
    tick(24);
    sp = p_rises; sf = f_rises; sc = c_rises;
    tick(40);
    check(p_rises[1] - sp[1] >= 4, "R9 re-enabled stoppable", p_rises[1] - sp[1], 4);
    check(f_rises[0] - sf[0] >= 4, "R9 re-enabled free", f_rises[0] - sf[0], 4);
    check(c_rises[1] - sc[1] >= 9, "R9 re-enabled pair", c_rises[1] - sc[1], 9);
  endtask

  task automatic t_mode_off();
    int sp [N_PCI]; int sc [N_CPU];
    do_reset(1'b0);
    pci_stop_n = 1'b0; cpu_stop_n = 1'b0;
    tick(24);
    sp = p_rises; sc = c_rises;
    tick(48);
    for (int i = 0; i < N_PCI; i++) check(p_rises[i] - sp[i] >= 5, "R8 bus stop ignored", p_rises[i] - sp[i], 5);
    for (int i = 0; i < N_CPU; i++) check(c_rises[i] - sc[i] >= 11, "R8 pair stop ignored", c_rises[i] - sc[i], 11);
    mode_pin = 1'b1;
    tick(8);
    sp = p_rises;
    tick(48);
    check(p_rises[0] - sp[0] >= 5, "R8 late mode change ignored", p_rises[0] - sp[0], 5);
    pci_stop_n = 1'b1; cpu_stop_n = 1'b1;
    do_reset(1'b1);
    tick(24);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_pci_stop();
    t_cpu_stop();
    t_complement();
    t_enables();
    t_mode_off();
    t_pci_stop();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule